// File: doc/BRIEF.md
# Interrupt Domain Register Bank

This block is the software-visible register file of one interrupt domain. A bus master reaches it through a simple request/response port that carries only 32-bit words. The bank holds the domain-wide enable, a mode field and a delivery target for every source, and the pending and enable bit of every source. These values drive the source gateway that sits beside it. Software sets and clears pending and enable bits in two ways. It can write bit vectors that cover 32 sources per word, or it can write the number of a single source to a by-number register.

Each request is answered exactly one cycle later, with read data and an error flag. The bank rejects any request whose size is not a full word, whose address is not word-aligned, or whose offset decodes to no register. The gateway reports its rectified input levels so that software can read them. It can also raise pending bits itself and drop them once it has delivered an interrupt. A write to the generate-message register produces a one-cycle strobe that carries the stored value. Source 0 does not exist, and its bit always reads 0.

Top module: `irb_regbank`

## Requirements
- R1: A request is accepted only when `req_size` is 2 (a 4-byte word) and `req_addr[1:0]` is 0. Any other size or alignment gets an error response and changes no state.
- R2: Every request gets `rsp_valid` in the cycle after it. An offset that maps to no register gets `rsp_err`=1. This covers vector words at index NW or above, where NW = ceil((NSRC+1)/32), and array entries above source NSRC.
- R3: The domain register sits at offset 0x0000, and only its bit 8 (domain enable, `dom_ie_o`) is writable. A read returns 0x8000_0004 ORed with the enable bit at bit 8, so bit 2 (message delivery mode) always reads 1.
- R4: Source mode words sit at 0x0004+4*(s-1) for s = 1..NSRC, so the first word belongs to source 1. When a write has bit 10 set, the mode is stored as 0. Otherwise bits 2:0 are stored. A read returns the stored 3-bit mode.
- R5: Target words sit at 0x3004+4*(s-1) for s = 1..NSRC. A write keeps the message ID in bits 10:0, the guest index in bits 17:12 and the hart index in bits 31:18, and clears every other bit. In other words, the stored value is the write data ANDed with 0xFFFF_F7FF.
- R6: Set-pending words sit at 0x1C00+4*w. Each 1 bit i of a write sets pending for source 32*w+i. A read returns the pending bits in the same packing. Bit positions that belong to source 0 or to sources above NSRC read 0 and cannot be set.
- R7: Clear-pending words sit at 0x1D00+4*w. Each 1 bit of a write clears the pending bit of the matching source. A read returns the rectified gateway inputs `gw_rect_in` in the same packing, with source 0 reading 0.
- R8: Set-enable words sit at 0x1E00+4*w and clear-enable words sit at 0x1F00+4*w. Each 1 bit of a write sets or clears the enable bit of the matching source. A set-enable word reads back the enable bits, and a clear-enable word always reads 0.
- R9: The by-number registers act on the single source whose number is the write data: set-pending at 0x1CDC, clear-pending at 0x1DDC, set-enable at 0x1EDC, clear-enable at 0x1FDC, and little-endian set-pending at 0x2000. A number of 0 or above NSRC has no effect. Each of these registers reads 0.
- R10: The set-pending register at 0x2004 reverses the byte order of the write data before it uses the data as a source number. It reads 0.
- R11: A write to the generate-message register at 0x3000 stores the data with bits 17:12 cleared, and a read returns the stored value. In the cycle after the write, `genmsg_stb_o` is 1 and `genmsg_o` holds the stored value.
- R12: Pending is updated as (old AND NOT clear) OR set. Clear is the union of bus clears and `gw_take`, and set is the union of bus sets and `gw_set`. When a set and a clear hit the same source in the same cycle, pending ends at 1.
- R13: `pend_o`, `en_o`, `src_mode_o` (3 bits per source) and `src_target_o` (32 bits per source) show the stored state one cycle after the write. After reset, every stored value is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of access size in bytes |
| req_addr | input | AW | Byte offset in the bank |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| gw_rect_in | input | NSRC+1 | Rectified source inputs from the gateway |
| gw_set | input | NSRC+1 | Gateway requests to set pending |
| gw_take | input | NSRC+1 | Gateway requests to clear pending after delivery |
| dom_ie_o | output | 1 | Domain interrupt enable |
| src_mode_o | output | 3*(NSRC+1) | Mode field per source |
| src_target_o | output | 32*(NSRC+1) | Target word per source |
| pend_o | output | NSRC+1 | Pending bits |
| en_o | output | NSRC+1 | Enable bits |
| genmsg_stb_o | output | 1 | Generate-message strobe |
| genmsg_o | output | 32 | Stored generate-message value |

## Verification
The two functions that can land in the same cycle are a bus write that sets or clears a pending bit and a gateway request that acts on the same bit. The bench provokes this by holding `gw_set` or `gw_take` on the source that a clear-by-number or set-by-number write names, for exactly the clock edge that takes the request. It then judges `pend_o` and the set-pending word read that follows against the rule that a set wins. The bench also sweeps every source through the array and number registers and compares the results against a model computed from the requirements.

// File: rtl/irb_pkg.sv
package irb_pkg;

  typedef enum logic [3:0] {
    OP_BAD, OP_DOM, OP_SCFG, OP_SPW, OP_SPN, OP_CPW, OP_CPN, OP_SEW,
    OP_SEN, OP_CEW, OP_CEN, OP_SPLE, OP_SPBE, OP_GEN, OP_TGT
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [15:0] idx;
  } dec_t;

  localparam int unsigned OFS_SCFG = 32'h0004;
  localparam int unsigned OFS_SPW  = 32'h1C00;
  localparam int unsigned OFS_SPN  = 32'h1CDC;
  localparam int unsigned OFS_CPW  = 32'h1D00;
  localparam int unsigned OFS_CPN  = 32'h1DDC;
  localparam int unsigned OFS_SEW  = 32'h1E00;
  localparam int unsigned OFS_SEN  = 32'h1EDC;
  localparam int unsigned OFS_CEW  = 32'h1F00;
  localparam int unsigned OFS_CEN  = 32'h1FDC;
  localparam int unsigned OFS_SPLE = 32'h2000;
  localparam int unsigned OFS_SPBE = 32'h2004;
  localparam int unsigned OFS_GEN  = 32'h3000;
  localparam int unsigned OFS_TGT  = 32'h3004;

  localparam int          MODE_W    = 3;
  localparam int          DLG_BIT   = 10;
  localparam int          IE_BIT    = 8;
  localparam logic [31:0] DOM_FIXED = 32'h8000_0004;
  localparam logic [31:0] TGT_KEEP  = 32'hFFFF_F7FF;
  localparam logic [31:0] GEN_KEEP  = 32'hFFFC_0FFF;

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/irb_decode.sv
module irb_decode
  import irb_pkg::*;
#(
  parameter int NSRC = 40,
  parameter int AW   = 14
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output dec_t          dec
);
  localparam int unsigned NW = (NSRC + 1 + 31) / 32;

  logic [31:0] off;

  function automatic logic in_rng(input logic [31:0] o, input int unsigned base,
                                  input int unsigned n);
    return (o >= base) && (o < base + 4 * n);
  endfunction

  always_comb begin
    dec = '{op: OP_BAD, idx: '0};
    off = 32'(addr);
    if (size == 2'd2 && addr[1:0] == 2'b00) begin
      if (off == 32'h0) begin
        dec.op = OP_DOM;
      end else if (in_rng(off, OFS_SCFG, NSRC)) begin
        dec.op  = OP_SCFG;
        dec.idx = 16'(((off - OFS_SCFG) >> 2) + 1);
      end else if (in_rng(off, OFS_SPW, NW)) begin
        dec.op  = OP_SPW;
        dec.idx = 16'((off - OFS_SPW) >> 2);
      end else if (off == OFS_SPN) begin
        dec.op = OP_SPN;
      end else if (in_rng(off, OFS_CPW, NW)) begin
        dec.op  = OP_CPW;
        dec.idx = 16'((off - OFS_CPW) >> 2);
      end else if (off == OFS_CPN) begin
        dec.op = OP_CPN;
      end else if (in_rng(off, OFS_SEW, NW)) begin
        dec.op  = OP_SEW;
        dec.idx = 16'((off - OFS_SEW) >> 2);
      end else if (off == OFS_SEN) begin
        dec.op = OP_SEN;
      end else if (in_rng(off, OFS_CEW, NW)) begin
        dec.op  = OP_CEW;
        dec.idx = 16'((off - OFS_CEW) >> 2);
      end else if (off == OFS_CEN) begin
        dec.op = OP_CEN;
      end else if (off == OFS_SPLE) begin
        dec.op = OP_SPLE;
      end else if (off == OFS_SPBE) begin
        dec.op = OP_SPBE;
      end else if (off == OFS_GEN) begin
        dec.op = OP_GEN;
      end else if (in_rng(off, OFS_TGT, NSRC)) begin
        dec.op  = OP_TGT;
        dec.idx = 16'(((off - OFS_TGT) >> 2) + 1);
      end
    end
  end
endmodule

// File: rtl/irb_srccfg.sv
module irb_srccfg
  import irb_pkg::*;
#(
  parameter int NSRC = 40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_mode,
  input  logic                       wr_tgt,
  input  logic [15:0]                idx,
  input  logic [31:0]                wdata,
  output logic [MODE_W-1:0]          rd_mode,
  output logic [31:0]                rd_tgt,
  output logic [MODE_W*(NSRC+1)-1:0] mode_flat,
  output logic [32*(NSRC+1)-1:0]     tgt_flat
);
  logic [MODE_W-1:0] mode_q [NSRC+1];
  logic [31:0]       tgt_q  [NSRC+1];
  logic [MODE_W-1:0] mode_n;
  logic [31:0]       tgt_n;

  always_comb begin
    mode_n = wdata[DLG_BIT] ? '0 : wdata[MODE_W-1:0];
    tgt_n  = wdata & TGT_KEEP;
  end

  assign mode_q[0] = '0;
  assign tgt_q[0]  = '0;
  assign mode_flat[MODE_W-1:0] = '0;
  assign tgt_flat[31:0]        = '0;

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    logic ce_mode, ce_tgt;
    assign ce_mode = wr_mode && (idx == 16'(s));
    assign ce_tgt  = wr_tgt  && (idx == 16'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[s] <= '0;
        tgt_q[s]  <= '0;
      end else begin
        if (ce_mode) mode_q[s] <= mode_n;
        if (ce_tgt)  tgt_q[s]  <= tgt_n;
      end
    end

    assign mode_flat[s*MODE_W +: MODE_W] = mode_q[s];
    assign tgt_flat[s*32 +: 32]          = tgt_q[s];
  end

  always_comb begin
    rd_mode = '0;
    rd_tgt  = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (idx == 16'(s)) begin
        rd_mode = mode_q[s];
        rd_tgt  = tgt_q[s];
      end
    end
  end
endmodule

// File: rtl/irb_bits.sv
module irb_bits #(
  parameter int NSRC = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC:0] bus_set_p,
  input  logic [NSRC:0] bus_clr_p,
  input  logic [NSRC:0] bus_set_e,
  input  logic [NSRC:0] bus_clr_e,
  input  logic [NSRC:0] gw_set,
  input  logic [NSRC:0] gw_take,
  output logic [NSRC:0] pend_q,
  output logic [NSRC:0] en_q
);
  localparam logic [NSRC:0] LIVE = ~(NSRC+1)'(1);

  logic [NSRC:0] set_p, clr_p, pend_n, en_n;
  logic          ce_p, ce_e;

  always_comb begin
    set_p  = (bus_set_p | gw_set) & LIVE;
    clr_p  = bus_clr_p | gw_take;
    pend_n = (pend_q & ~clr_p) | set_p;
    en_n   = ((en_q & ~bus_clr_e) | bus_set_e) & LIVE;
    ce_p   = |{set_p, clr_p};
    ce_e   = |{bus_set_e, bus_clr_e};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (ce_p) pend_q <= pend_n;
      if (ce_e) en_q   <= en_n;
    end
  end

  // R12
  gw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gw_set & LIVE)) |=> ((pend_q & $past(gw_set & LIVE)) == $past(gw_set & LIVE)));

  // R12
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gw_take & ~(gw_set | bus_set_p))) |=>
      ((pend_q & $past(gw_take & ~(gw_set | bus_set_p))) == '0));
endmodule

// File: rtl/irb_regbank.sv
module irb_regbank
  import irb_pkg::*;
#(
  parameter int NSRC = 40,
  parameter int AW   = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [1:0]                 req_size,
  input  logic [AW-1:0]              req_addr,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [31:0]                rsp_rdata,
  input  logic [NSRC:0]              gw_rect_in,
  input  logic [NSRC:0]              gw_set,
  input  logic [NSRC:0]              gw_take,
  output logic                       dom_ie_o,
  output logic [MODE_W*(NSRC+1)-1:0] src_mode_o,
  output logic [32*(NSRC+1)-1:0]     src_target_o,
  output logic [NSRC:0]              pend_o,
  output logic [NSRC:0]              en_o,
  output logic                       genmsg_stb_o,
  output logic [31:0]                genmsg_o
);
  localparam int NW   = (NSRC + 1 + 31) / 32;
  localparam int PADW = NW * 32;

  dec_t               dec;
  logic               wr, rd;
  logic [31:0]        wswap;
  logic [MODE_W-1:0]  rd_mode;
  logic [31:0]        rd_tgt;
  logic [NSRC:0]      bset_p, bclr_p, bset_e, bclr_e;
  logic [NSRC:0]      pend_q, en_q;
  logic [PADW-1:0]    pend_pad, en_pad, rect_pad;
  logic [31:0]        rdata_n;

  logic               rsp_valid_q, rsp_err_q, ie_q, stb_q;
  logic [31:0]        rdata_q, gen_q;
  logic               ie_ce, gen_ce;

  irb_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .dec  (dec)
  );

  assign wr    = req_valid && req_write;
  assign rd    = req_valid && !req_write;
  assign wswap = swap32(req_wdata);

  irb_srccfg #(.NSRC(NSRC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr && dec.op == OP_SCFG),
    .wr_tgt    (wr && dec.op == OP_TGT),
    .idx       (dec.idx),
    .wdata     (req_wdata),
    .rd_mode   (rd_mode),
    .rd_tgt    (rd_tgt),
    .mode_flat (src_mode_o),
    .tgt_flat  (src_target_o)
  );

  assign bset_p[0] = 1'b0;
  assign bclr_p[0] = 1'b0;
  assign bset_e[0] = 1'b0;
  assign bclr_e[0] = 1'b0;

  for (genvar s = 1; s <= NSRC; s++) begin : g_hit
    logic wsel, wbit, nhit, bhit;
    assign wsel = (dec.idx == 16'(s / 32));
    assign wbit = req_wdata[s % 32];
    assign nhit = (req_wdata == 32'(s));
    assign bhit = (wswap == 32'(s));
    assign bset_p[s] = wr && ((dec.op == OP_SPW && wsel && wbit) ||
                              ((dec.op == OP_SPN || dec.op == OP_SPLE) && nhit) ||
                              (dec.op == OP_SPBE && bhit));
    assign bclr_p[s] = wr && ((dec.op == OP_CPW && wsel && wbit) ||
                              (dec.op == OP_CPN && nhit));
    assign bset_e[s] = wr && ((dec.op == OP_SEW && wsel && wbit) ||
                              (dec.op == OP_SEN && nhit));
    assign bclr_e[s] = wr && ((dec.op == OP_CEW && wsel && wbit) ||
                              (dec.op == OP_CEN && nhit));
  end

  irb_bits #(.NSRC(NSRC)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_set_p (bset_p),
    .bus_clr_p (bclr_p),
    .bus_set_e (bset_e),
    .bus_clr_e (bclr_e),
    .gw_set    (gw_set),
    .gw_take   (gw_take),
    .pend_q    (pend_q),
    .en_q      (en_q)
  );

  assign pend_pad = PADW'(pend_q);
  assign en_pad   = PADW'(en_q);
  assign rect_pad = PADW'(gw_rect_in & ~(NSRC+1)'(1));

  always_comb begin
    rdata_n = '0;
    if (rd) begin
      case (dec.op)
        OP_DOM:  rdata_n = DOM_FIXED | (32'(ie_q) << IE_BIT);
        OP_SCFG: rdata_n = 32'(rd_mode);
        OP_TGT:  rdata_n = rd_tgt;
        OP_GEN:  rdata_n = gen_q;
        OP_SPW, OP_CPW, OP_SEW: begin
          for (int w = 0; w < NW; w++) begin
            if (dec.idx == 16'(w)) begin
              if (dec.op == OP_SPW)      rdata_n = pend_pad[w*32 +: 32];
              else if (dec.op == OP_CPW) rdata_n = rect_pad[w*32 +: 32];
              else                       rdata_n = en_pad[w*32 +: 32];
            end
          end
        end
        default: rdata_n = '0;
      endcase
    end
  end

  assign ie_ce  = wr && dec.op == OP_DOM;
  assign gen_ce = wr && dec.op == OP_GEN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rdata_q     <= '0;
      ie_q        <= 1'b0;
      gen_q       <= '0;
      stb_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      rsp_err_q   <= req_valid && dec.op == OP_BAD;
      rdata_q     <= rdata_n;
      stb_q       <= gen_ce;
      if (ie_ce)  ie_q  <= req_wdata[IE_BIT];
      if (gen_ce) gen_q <= req_wdata & GEN_KEEP;
    end
  end

  assign rsp_valid    = rsp_valid_q;
  assign rsp_err      = rsp_err_q;
  assign rsp_rdata    = rdata_q;
  assign dom_ie_o     = ie_q;
  assign pend_o       = pend_q;
  assign en_o         = en_q;
  assign genmsg_stb_o = stb_q;
  assign genmsg_o     = gen_q;

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |=> rsp_err);

  // R3
  dom_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && dec.op == OP_DOM) |=> (rsp_rdata[2] && rsp_rdata[31]));

  // R8
  clr_en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && dec.op == OP_CEW) |=> (rsp_rdata == 32'h0));

  // R11
  gen_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.op == OP_GEN) |=> (genmsg_stb_o && genmsg_o[17:12] == 6'h0));
endmodule

// File: tb/sim_irb_regbank.sv
`timescale 1ns/1ps
module sim_irb_regbank;
  localparam int NSRC = 40;
  localparam int AW   = 14;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [1:0]        req_size;
  logic [AW-1:0]     req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [NSRC:0]     gw_rect_in, gw_set, gw_take;
  logic              dom_ie_o;
  logic [3*(NSRC+1)-1:0]  src_mode_o;
  logic [32*(NSRC+1)-1:0] src_target_o;
  logic [NSRC:0]     pend_o, en_o;
  logic              genmsg_stb_o;
  logic [31:0]       genmsg_o;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [31:0] rdv;
  logic        erv, vv, stbv;
  logic [NSRC:0] pm, em;
  logic [2:0]  mm [NSRC+1];
  logic [31:0] tm [NSRC+1];

  always #2 clk = ~clk;

  irb_regbank #(.NSRC(NSRC), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .gw_rect_in(gw_rect_in), .gw_set(gw_set), .gw_take(gw_take),
    .dom_ie_o(dom_ie_o), .src_mode_o(src_mode_o), .src_target_o(src_target_o),
    .pend_o(pend_o), .en_o(en_o), .genmsg_stb_o(genmsg_stb_o), .genmsg_o(genmsg_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic xact(input logic w, input logic [1:0] sz, input logic [AW-1:0] a,
                      input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rdv = rsp_rdata; erv = rsp_err; vv = rsp_valid; stbv = genmsg_stb_o;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    xact(1'b1, 2'd2, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    xact(1'b0, 2'd2, a, 32'h0);
  endtask

  function automatic logic [31:0] pword(input logic [NSRC:0] v, input int w);
    logic [63:0] p;
    p = 64'(v);
    return p[w*32 +: 32];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_size = 2'd2;
    req_addr = '0; req_wdata = '0;
    gw_rect_in = '0; gw_set = '0; gw_take = '0;
    pm = '0; em = '0;
    for (int s = 0; s <= NSRC; s++) begin mm[s] = '0; tm[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 reset pend", 64'(pend_o), 64'(0));
    chk("R13 reset en", 64'(en_o), 64'(0));
    chk("R13 reset ie", 64'(dom_ie_o), 64'(0));
    chk("R2 idle rsp_valid", 64'(rsp_valid), 64'(0));

    // R3 domain register
    wr(14'h0000, 32'hFFFF_FFFF);
    chk("R2 rsp_valid", 64'(vv), 64'(1));
    chk("R3 ie out", 64'(dom_ie_o), 64'(1));
    rd(14'h0000);
    chk("R3 read ie=1", 64'(rdv), 64'h8000_0104);
    wr(14'h0000, 32'hFFFF_FEFF);
    rd(14'h0000);
    chk("R3 read ie=0", 64'(rdv), 64'h8000_0004);

    // R4 source mode sweep
    for (int s = 1; s <= NSRC; s++) begin
      logic [31:0] d;
      d = 32'(s) * 32'h9E37_79B1;
      d[10] = (s % 4 == 0);
      mm[s] = d[10] ? 3'd0 : d[2:0];
      wr(14'(32'h0004 + 4 * (s - 1)), d);
      chk("R2 scfg no err", 64'(erv), 64'(0));
    end
    for (int s = 1; s <= NSRC; s++) begin
      rd(14'(32'h0004 + 4 * (s - 1)));
      chk("R4 mode read", 64'(rdv), 64'(mm[s]));
      chk("R13 mode port", 64'(src_mode_o[s*3 +: 3]), 64'(mm[s]));
    end
    wr(14'(32'h0004 + 4 * NSRC), 32'h1);
    chk("R2 scfg past end err", 64'(erv), 64'(1));

    // R5 target sweep
    for (int s = 1; s <= NSRC; s++) begin
      logic [31:0] d;
      d = ~(32'(s) * 32'h0101_0101) ^ 32'(s << 11);
      tm[s] = d & 32'hFFFF_F7FF;
      wr(14'(32'h3004 + 4 * (s - 1)), d);
    end
    for (int s = 1; s <= NSRC; s++) begin
      rd(14'(32'h3004 + 4 * (s - 1)));
      chk("R5 target read", 64'(rdv), 64'(tm[s]));
      chk("R13 target port", 64'(src_target_o[s*32 +: 32]), 64'(tm[s]));
    end

    // R1 size and alignment
    xact(1'b1, 2'd1, 14'h0000, 32'h100);
    chk("R1 half size err", 64'(erv), 64'(1));
    chk("R1 no state change", 64'(dom_ie_o), 64'(0));
    xact(1'b1, 2'd2, 14'h0002, 32'h100);
    chk("R1 misaligned err", 64'(erv), 64'(1));
    xact(1'b0, 2'd3, 14'h0000, 32'h0);
    chk("R1 size8 err", 64'(erv), 64'(1));

    // R2 unmapped
    rd(14'h1C08);
    chk("R2 word past NW err", 64'(erv), 64'(1));
    rd(14'h2FF0);
    chk("R2 hole err", 64'(erv), 64'(1));
    rd(14'(32'h3004 + 4 * NSRC));
    chk("R2 target past end err", 64'(erv), 64'(1));

    // R9 R10 set pending by number through three registers
    for (int s = 0; s <= NSRC + 1; s++) begin
      if (s % 2 == 1 || s == 0 || s == NSRC + 1) begin
        logic [31:0] n;
        n = 32'(s);
        if (s % 3 == 0)      wr(14'h1CDC, n);
        else if (s % 3 == 1) wr(14'h2000, n);
        else                 wr(14'h2004, {n[7:0], n[15:8], n[23:16], n[31:24]});
        if (s >= 1 && s <= NSRC) pm[s] = 1'b1;
      end
    end
    chk("R9 R10 pend port", 64'(pend_o), 64'(pm));
    rd(14'h1C00);
    chk("R6 pend word0", 64'(rdv), 64'(pword(pm, 0)));
    rd(14'h1C04);
    chk("R6 pend word1", 64'(rdv), 64'(pword(pm, 1)));
    rd(14'h1CDC);
    chk("R9 num reg reads 0", 64'(rdv), 64'(0));
    rd(14'h2004);
    chk("R10 be reg reads 0", 64'(rdv), 64'(0));

    // R7 clear pending word and number, rectified read
    wr(14'h1D00, 32'hAAAA_AAAA);
    pm[31:0] = pm[31:0] & ~32'hAAAA_AAAA;
    wr(14'h1DDC, 32'd33);
    pm[33] = 1'b0;
    wr(14'h1DDC, 32'd0);
    rd(14'h1C00);
    chk("R7 pend after clr w0", 64'(rdv), 64'(pword(pm, 0)));
    rd(14'h1C04);
    chk("R7 pend after clr num", 64'(rdv), 64'(pword(pm, 1)));
    gw_rect_in = 41'h1_5A3C_C3F1;
    rd(14'h1D00);
    chk("R7 rect word0", 64'(rdv), 64'(pword(gw_rect_in & ~41'h1, 0)));
    rd(14'h1D04);
    chk("R7 rect word1", 64'(rdv), 64'(pword(gw_rect_in, 1)));

    // R6 set word beyond last source
    wr(14'h1C04, 32'hFFFF_FFFF);
    pm[NSRC:32] = '1;
    wr(14'h1C00, 32'h0000_0001);
    rd(14'h1C04);
    chk("R6 word1 upper bits 0", 64'(rdv), 64'(32'h1FF));
    rd(14'h1C00);
    chk("R6 source0 not set", 64'(rdv), 64'(pword(pm, 0)));

    // R8 enable words and numbers
    wr(14'h1E00, 32'h0000_FFFF); em[31:1] = 31'h7FFF;
    wr(14'h1E04, 32'h0000_0003); em[33:32] = 2'b11;
    wr(14'h1EDC, 32'd20);        em[20] = 1'b1;
    wr(14'h1FDC, 32'd3);         em[3] = 1'b0;
    wr(14'h1F00, 32'h0000_0F00); em[11:8] = 4'h0;
    wr(14'h1EDC, 32'd41);
    rd(14'h1E00);
    chk("R8 en word0", 64'(rdv), 64'(pword(em, 0)));
    rd(14'h1E04);
    chk("R8 en word1", 64'(rdv), 64'(pword(em, 1)));
    rd(14'h1F00);
    chk("R8 clr-en reads 0", 64'(rdv), 64'(0));
    rd(14'h1EDC);
    chk("R9 set-en num reads 0", 64'(rdv), 64'(0));
    chk("R13 en port", 64'(en_o), 64'(em));

    // R11 generate message
    wr(14'h3000, 32'hFFFF_FFFF);
    chk("R11 strobe", 64'(stbv), 64'(1));
    chk("R11 strobe value", 64'(genmsg_o), 64'hFFFC_0FFF);
    rd(14'h3000);
    chk("R11 readback", 64'(rdv), 64'hFFFC_0FFF);
    chk("R11 strobe one cycle", 64'(stbv), 64'(0));

    // R12 concurrent gateway and bus on the same source
    gw_set = 41'(1) << 6;
    wr(14'h1DDC, 32'd6);
    gw_set = '0;
    pm[6] = 1'b1;
    chk("R12 set beats bus clear", 64'(pend_o[6]), 64'(1));
    gw_take = 41'(1) << 7;
    wr(14'h1CDC, 32'd7);
    gw_take = '0;
    pm[7] = 1'b1;
    chk("R12 bus set beats take", 64'(pend_o[7]), 64'(1));
    gw_take = 41'(1) << 7;
    @(posedge clk); @(negedge clk);
    gw_take = '0;
    pm[7] = 1'b0;
    rd(14'h1C00);
    chk("R12 take clears", 64'(rdv), 64'(pword(pm, 0)));

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule